// File: doc/BRIEF.md
# Fundamental-Mode Transition-Map Stepper

This block is a clocked model of a two-input, two-state-bit asynchronous state machine, meant for checking whether a candidate next-state map behaves well before it is built as real gates. Each clock cycle stands for one propagation delay through the imagined logic. A 16-entry next-state map is loaded through a write port. It is indexed by the total state, which is the external input pair AB together with the present state ZQ.

Applying a new input pair moves the machine at once to the map column for that pair, with the present state unchanged. The block then takes vertical steps, one per cycle, until the looked-up next state equals the present state. It reports the final state and the number of steps taken. It flags three faults: an input event that changes both input bits, a step that flips both state bits at once (a race), and settling that does not finish within a bounded number of steps (an oscillation). New events are refused while settling is in progress.

Top module: `tmap_stepper`

## Requirements
- R1: A synchronous active-high reset loads the present state from `rst_state` and sets the input pair to 00. It clears `busy`, `done`, `steps` and all three flags. It fills every map entry with its own row value, so that every total state is stable.
- R2: When `tbl_we` is high at a clock edge, the map entry at `tbl_addr` takes `tbl_data`. Address bits [3:2] hold the input pair AB and bits [1:0] hold the present state ZQ. The data value is the next state ZQ.
- R3: When `ev_valid` is high and `busy` is low, an input pair that differs from `cur_ab` in at most one bit is accepted at that edge. After the edge, `cur_ab` equals the new pair, `cur_zq` is unchanged, `busy` is high, and `steps`, `race`, `osc` and `fm_err` are cleared.
- R4: While `busy` is high, `ev_valid` is ignored and `cur_ab` does not change.
- R5: On each busy cycle, if the entry at the current total state differs from `cur_zq`, `cur_zq` takes that entry and `steps` increments. If it equals `cur_zq`, `busy` falls and `done` pulses high for one cycle.
- R6: An event presented while idle that changes both input bits is rejected. `cur_ab` and `cur_zq` keep their values, `busy` stays low, `fm_err` is set, `race`, `osc` and `steps` are cleared, and `done` pulses.
- R7: `race` is set when a settling step changes both state bits. It stays set until the next event.
- R8: Settling stops after `MAX_STEPS` steps (default 4). If the state is still unstable at that point, `osc` is set, `busy` falls and `done` pulses. `cur_zq` then holds the value reached by the last step, and `steps` equals `MAX_STEPS`.
- R9: `stable` is high exactly when the map entry at the current total state equals `cur_zq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per propagation delay |
| rst | input | 1 | Synchronous reset, active high |
| rst_state | input | 2 | Present state loaded at reset |
| tbl_we | input | 1 | Map write enable |
| tbl_addr | input | 4 | Map index {AB, ZQ} |
| tbl_data | input | 2 | Next state written to the map |
| ev_valid | input | 1 | Input event request |
| ev_ab | input | 2 | New input pair AB |
| busy | output | 1 | Settling in progress |
| done | output | 1 | One-cycle pulse when an event has been resolved |
| stable | output | 1 | Current total state is stable |
| cur_ab | output | 2 | Applied input pair |
| cur_zq | output | 2 | Present state ZQ |
| steps | output | $clog2(MAX_STEPS+1) | Vertical steps taken for the last event |
| race | output | 1 | A step changed both state bits |
| osc | output | 1 | Settling did not finish within MAX_STEPS |
| fm_err | output | 1 | Last event changed both input bits |

## Verification
The map is loaded with columns chosen so that single-bit input events exercise several cases: zero-step settling, a two-step walk, a one-step race, and a four-step cycle between two unstable rows. These cases separate a correct step counter from one that stops early or counts the final lookup. They also separate a race detector from a plain change detector, and an oscillation limit from an endless loop. A two-bit input change tells rejection apart from silent acceptance. A second event pulsed during settling, on an input pair that would otherwise be legal, shows whether refusal while busy holds. A write that makes the current total state unstable, followed by a write that restores it, shows the map index ordering through the `stable` output.

// File: rtl/tmap_stepper.sv
module tmap_stepper #(
  parameter int MAX_STEPS = 4,
  localparam int SW = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rst_state,
  input  logic          tbl_we,
  input  logic [3:0]    tbl_addr,
  input  logic [1:0]    tbl_data,
  input  logic          ev_valid,
  input  logic [1:0]    ev_ab,
  output logic          busy,
  output logic          done,
  output logic          stable,
  output logic [1:0]    cur_ab,
  output logic [1:0]    cur_zq,
  output logic [SW-1:0] steps,
  output logic          race,
  output logic          osc,
  output logic          fm_err
);
  localparam int DEPTH = 16;

  logic [1:0] map_q [DEPTH];
  logic [1:0] nxt;
  logic       multi, accept, reject, at_limit;

  assign nxt      = map_q[{cur_ab, cur_zq}];
  assign stable   = (nxt == cur_zq);
  assign multi    = ($countones(ev_ab ^ cur_ab) > 1);
  assign accept   = ev_valid && !busy && !multi;
  assign reject   = ev_valid && !busy && multi;
  assign at_limit = (steps == SW'(MAX_STEPS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) map_q[i] <= 2'(i);
      cur_ab <= 2'b00;
      cur_zq <= rst_state;
      busy   <= 1'b0;
      done   <= 1'b0;
      steps  <= '0;
      race   <= 1'b0;
      osc    <= 1'b0;
      fm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tbl_we) map_q[tbl_addr] <= tbl_data;
      if (accept) begin
        cur_ab <= ev_ab;
        busy   <= 1'b1;
        steps  <= '0;
        race   <= 1'b0;
        osc    <= 1'b0;
        fm_err <= 1'b0;
      end else if (reject) begin
        fm_err <= 1'b1;
        done   <= 1'b1;
        steps  <= '0;
        race   <= 1'b0;
        osc    <= 1'b0;
      end else if (busy) begin
        if (stable) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (at_limit) begin
          osc  <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cur_zq <= nxt;
          steps  <= steps + 1'b1;
          if (&(nxt ^ cur_zq)) race <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmap_stepper_chk.sv
module tmap_stepper_chk #(
  parameter int MAX_STEPS = 4,
  localparam int SW = $clog2(MAX_STEPS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_valid,
  input logic [1:0]    ev_ab,
  input logic          busy,
  input logic          done,
  input logic [1:0]    cur_ab,
  input logic [1:0]    cur_zq,
  input logic [SW-1:0] steps,
  input logic          osc,
  input logic          fm_err
);
  a_r4_ab_held_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cur_ab));

  a_r3_state_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(cur_zq));

  a_r6_two_bit_rejected: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !busy && ($countones(ev_ab ^ cur_ab) > 1)) |=> (fm_err && done && !busy && $stable(cur_ab)));

  a_r8_osc_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(osc) |-> (steps == SW'(MAX_STEPS) && done));

  a_r5_steps_bounded: assert property (@(posedge clk) disable iff (rst)
    steps <= SW'(MAX_STEPS));

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind tmap_stepper tmap_stepper_chk #(.MAX_STEPS(MAX_STEPS)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ab(ev_ab), .busy(busy),
  .done(done), .cur_ab(cur_ab), .cur_zq(cur_zq), .steps(steps),
  .osc(osc), .fm_err(fm_err)
);

// File: tb/test_tmap_stepper.sv
`timescale 1ns/1ps
module test_tmap_stepper;
  localparam int MAXS = 4;

  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] rst_state = 2'b10;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [1:0] tbl_data = '0;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_ab = '0;
  logic       busy, done, stable, race, osc, fm_err;
  logic [1:0] cur_ab, cur_zq;
  logic [2:0] steps;

  tmap_stepper #(.MAX_STEPS(MAXS)) i_tmap_stepper (
    .clk(clk), .rst(rst), .rst_state(rst_state), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .ev_valid(ev_valid),
    .ev_ab(ev_ab), .busy(busy), .done(done), .stable(stable),
    .cur_ab(cur_ab), .cur_zq(cur_zq), .steps(steps), .race(race),
    .osc(osc), .fm_err(fm_err));

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0] ab, zq;
    logic [2:0] st;
    logic race, osc, err;
  } exp_t;

  exp_t       q[$];
  int         checks = 0, errors = 0;
  logic [1:0] mtbl [16];
  logic [1:0] mab, mzq;
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) chk(0, "R5 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cur_zq == e.zq, "R5 final state", cur_zq, e.zq);
        chk(cur_ab == e.ab, "R3 applied inputs", cur_ab, e.ab);
        chk(steps == e.st, "R5 step count", steps, e.st);
        chk(race == e.race, "R7 race flag", race, e.race);
        chk(osc == e.osc, "R8 oscillation flag", osc, e.osc);
        chk(fm_err == e.err, "R6 input error flag", fm_err, e.err);
        chk(busy == 1'b0, "R5 idle at done", busy, 0);
        if (!e.err) chk(stable == !e.osc, "R9 stable output", stable, !e.osc);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(negedge clk); tbl_we = 1'b0;
    mtbl[a] = d;
  endtask

  function automatic exp_t predict(input logic [1:0] ab);
    exp_t e;
    logic [1:0] n;
    e = '0;
    if ($countones(ab ^ mab) > 1) begin
      e.err = 1'b1;
    end else begin
      mab = ab;
      forever begin
        n = mtbl[{mab, mzq}];
        if (n == mzq) break;
        if (e.st == 3'(MAXS)) begin e.osc = 1'b1; break; end
        if ((n ^ mzq) == 2'b11) e.race = 1'b1;
        mzq = n;
        e.st++;
      end
    end
    e.ab = mab;
    e.zq = mzq;
    return e;
  endfunction

  task automatic apply(input logic [1:0] ab, input bit poke_busy, input logic [1:0] other);
    q.push_back(predict(ab));
    @(negedge clk); ev_valid = 1'b1; ev_ab = ab;
    @(negedge clk);
    if (poke_busy) begin
      chk(busy == 1'b1, "R4 busy during settling", busy, 1);
      ev_ab = other;
      @(negedge clk);
    end
    ev_valid = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mtbl[i] = 2'(i);
    mab = 2'b00; mzq = rst_state;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_zq == 2'b10, "R1 reset state", cur_zq, 2);
    chk(cur_ab == 2'b00, "R1 reset inputs", cur_ab, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(steps == 3'd0, "R1 reset steps", steps, 0);
    chk({race, osc, fm_err} == 3'b000, "R1 reset flags", {race, osc, fm_err}, 0);
    chk(stable == 1'b1, "R1 reset map stable", stable, 1);

    apply(2'b01, 0, 2'b00);                      // R3 zero-step settle
    wr(4'b0110, 2'b11);                          // R2 entry {AB=01,ZQ=10}
    chk(stable == 1'b0, "R2 write at index {AB,ZQ}", stable, 0);
    wr(4'b0110, 2'b10);
    chk(stable == 1'b1, "R2 restore entry", stable, 1);

    wr(4'b1110, 2'b11); wr(4'b1111, 2'b01);
    apply(2'b11, 0, 2'b00);                      // R5 two steps

    wr(4'b1001, 2'b10);
    apply(2'b10, 0, 2'b00);                      // R7 race step

    apply(2'b01, 0, 2'b00);                      // R6 both inputs change

    wr(4'b0010, 2'b00); wr(4'b0000, 2'b01);
    wr(4'b0001, 2'b11); wr(4'b0011, 2'b01);
    apply(2'b00, 0, 2'b00);                      // R8 oscillation

    wr(4'b0101, 2'b00);
    apply(2'b01, 1, 2'b11);                      // R4 refused second event
    chk(cur_ab == 2'b01, "R4 refused event left inputs", cur_ab, 1);

    apply(2'b11, 0, 2'b00);                      // R3 follow-up settles
    apply(2'b11, 0, 2'b00);                      // R3 same pair again

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule